// File: doc/BRIEF.md
# Plus-Selection Evolutionary QUBO Search Core

This block searches for an n-bit vector that minimizes a quadratic binary objective. The objective is held as a signed coefficient matrix that is written through a simple write port. The search is a (mu+lambda) evolutionary loop. A population of MU parent vectors and their energies is kept. In each generation LAMBDA offspring are built from the parents and scored by an energy evaluator inside the block. The MU lowest-energy vectors of the merged parent and offspring pool become the next parents.

All random choices come from a 32-bit maximal-length LFSR that is loaded from a seed input at start. The search ends after a fixed number of generations, or earlier when abort is raised during offspring creation. The block then holds the best vector found and its energy until the next start. The host computes the coefficients from its learning problem, loads them, pulses start and waits for done.

Top module: `qubo_evo_core`

## Requirements
- R1: After reset, busy and done are both 0.
- R2: A start pulse while idle or done loads the LFSR with seed (a zero seed is replaced by 1), clears done and raises busy. Parent k (k = 0..MU-1) is the low N bits of the LFSR value in the k-th busy cycle, so parent 0 equals seed[N-1:0].
- R3: The energy of vector x is the signed sum of Q[i][j] over all i <= j with x[i] = x[j] = 1. A coefficient write with coef_we = 1 stores coef_data, a B-bit two's complement value, at (coef_row, coef_col) only when coef_row <= coef_col. Writes with row > col have no effect.
- R4: Each offspring is a uniform crossover of parents a = r[15:8] mod MU and b = r[23:16] mod MU, where r is the LFSR value. Bit i comes from a when r[i] = 1 and from b otherwise. Exactly one bit is then flipped, at position r[31:24] mod N.
- R5: Selection keeps the MU lowest energies of the pool in ascending order. On equal energy a parent beats an offspring, and a lower index beats a higher one. With an all-zero matrix, the parents therefore never change.
- R6: While busy, best_energy never increases, and from the end of initialization onward best_energy is the energy of best_vec.
- R7: Without abort, done rises exactly MU + BUDGET*(LAMBDA+1) cycles after the clock edge that samples start.
- R8: abort sampled high during offspring creation raises done at the next edge and keeps the best result found so far.
- R9: While done is high and start is low, done, best_vec and best_energy do not change, including when the coefficients are rewritten.
- R10: On problems with a single planted optimum that a sequence of improving one-bit moves reaches, best_energy equals the exhaustive minimum when done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search when idle or done |
| abort | input | 1 | Stop early during offspring creation |
| seed | input | 32 | LFSR seed loaded at start |
| coef_we | input | 1 | Coefficient write strobe |
| coef_row | input | $clog2(N) | Coefficient row index |
| coef_col | input | $clog2(N) | Coefficient column index |
| coef_data | input | B | Signed coefficient value |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, result held |
| best_vec | output | N | Lowest-energy vector found |
| best_energy | output | B+2*$clog2(N)+1 | Signed energy of best_vec |

## Verification
A run takes MU initialization cycles followed by BUDGET generations of LAMBDA+1 cycles each. The bench counts edges from the one that samples start and expects done exactly at that count. The abort result is due one edge after abort is sampled. The bench therefore samples one time unit after each rising edge and checks the flag at the exact edge, never within a window. During the run it reads best_energy every cycle to check that the value never rises. It then compares the final energy with its own exhaustive search, and with its own recomputation of the energy of best_vec.

// File: rtl/qubo_evo_pkg.sv
package qubo_evo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_GEN,
    ST_SEL,
    ST_DONE
  } evo_state_e;

  localparam logic [31:0] LFSR_POLY = 32'h8020_0003;
  localparam logic [31:0] LFSR_ONE  = 32'h0000_0001;

  // one step of a right-shifting Galois LFSR, maximal length
  function automatic logic [31:0] lfsr_advance(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_POLY : 32'h0);
  endfunction

endpackage

// File: rtl/qubo_lfsr.sv
module qubo_lfsr
  import qubo_evo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        step,
  output logic [31:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n)       value <= LFSR_ONE;
    else if (load)    value <= (seed == 32'h0) ? LFSR_ONE : seed;
    else if (step)    value <= lfsr_advance(value);
  end

endmodule

// File: rtl/qubo_energy.sv
module qubo_energy #(
  parameter int N  = 8,
  parameter int B  = 8,
  parameter int IW = $clog2(N),
  parameter int EW = B + 2 * IW + 1
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IW-1:0]        row,
  input  logic [IW-1:0]        col,
  input  logic [B-1:0]         data,
  input  logic [N-1:0]         cand,
  output logic signed [EW-1:0] energy
);

  logic signed [B-1:0] q [N][N];

  // only the upper triangle including the diagonal is stored (R3)
  always_ff @(posedge clk) begin
    if (we && (row <= col)) q[row][col] <= data;
  end

  always_comb begin
    energy = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = i; j < N; j++) begin
        if (cand[i] && cand[j]) energy = energy + EW'(q[i][j]);
      end
    end
  end

endmodule

// File: rtl/qubo_select.sv
module qubo_select #(
  parameter int N      = 8,
  parameter int MU     = 4,
  parameter int LAMBDA = 4,
  parameter int EW     = 15,
  parameter int POOL   = MU + LAMBDA,
  parameter int PCW    = $clog2(POOL + 1)
) (
  input  logic [POOL-1:0][N-1:0]  pool_v,
  input  logic [POOL-1:0][EW-1:0] pool_e,
  output logic [MU-1:0][N-1:0]    next_v,
  output logic [MU-1:0][EW-1:0]   next_e,
  output logic [MU-1:0][POOL-1:0] hit
);

  logic [PCW-1:0] rank [POOL];

  // rank = number of pool members that beat this one; pool index order
  // places parents first, so "lower index wins ties" also prefers parents
  always_comb begin
    for (int c = 0; c < POOL; c++) begin
      rank[c] = '0;
      for (int d = 0; d < POOL; d++) begin
        if (d != c) begin
          if (($signed(pool_e[d]) < $signed(pool_e[c])) ||
              ((pool_e[d] == pool_e[c]) && (d < c)))
            rank[c] = rank[c] + PCW'(1);
        end
      end
    end
    for (int s = 0; s < MU; s++) begin
      next_v[s] = '0;
      next_e[s] = '0;
      for (int c = 0; c < POOL; c++) begin
        hit[s][c] = (rank[c] == PCW'(s));
        if (hit[s][c]) begin
          next_v[s] = next_v[s] | pool_v[c];
          next_e[s] = next_e[s] | pool_e[c];
        end
      end
    end
  end

endmodule

// File: rtl/qubo_evo_core.sv
module qubo_evo_core
  import qubo_evo_pkg::*;
#(
  parameter int N      = 8,
  parameter int B      = 8,
  parameter int MU     = 4,
  parameter int LAMBDA = 4,
  parameter int BUDGET = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          abort,
  input  logic [31:0]                   seed,
  input  logic                          coef_we,
  input  logic [$clog2(N)-1:0]          coef_row,
  input  logic [$clog2(N)-1:0]          coef_col,
  input  logic [B-1:0]                  coef_data,
  output logic                          busy,
  output logic                          done,
  output logic [N-1:0]                  best_vec,
  output logic [B+2*$clog2(N)+1-1:0]    best_energy
);

  localparam int IW   = $clog2(N);
  localparam int EW   = B + 2 * IW + 1;
  localparam int PW   = $clog2(MU);
  localparam int OW   = $clog2(LAMBDA);
  localparam int CW   = (PW > OW) ? PW : OW;
  localparam int GW   = $clog2(BUDGET + 1);
  localparam int POOL = MU + LAMBDA;
  localparam logic signed [EW-1:0] E_MAX = {1'b0, {(EW-1){1'b1}}};

  evo_state_e state;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gen;
  logic [MU-1:0][N-1:0]      par_v;
  logic [MU-1:0][EW-1:0]     par_e;
  logic [LAMBDA-1:0][N-1:0]  off_v;
  logic [LAMBDA-1:0][EW-1:0] off_e;
  logic [N-1:0]              best_v;
  logic signed [EW-1:0]      best_e;

  // random fields taken from the LFSR (R4)
  function automatic logic [PW-1:0] pick_parent(input logic [7:0] f);
    logic [7:0] t;
    t = f % 8'(MU);
    return t[PW-1:0];
  endfunction

  function automatic logic [IW-1:0] pick_bit(input logic [7:0] f);
    logic [7:0] t;
    t = f % 8'(N);
    return t[IW-1:0];
  endfunction

  logic [31:0]          r;
  logic                 start_ok;
  logic [PW-1:0]        sel_a, sel_b;
  logic [IW-1:0]        flip_pos;
  logic [N-1:0]         xover, child, cand;
  logic signed [EW-1:0] cand_e;
  logic                 in_init, in_gen, in_sel;

  assign in_init  = (state == ST_INIT);
  assign in_gen   = (state == ST_GEN);
  assign in_sel   = (state == ST_SEL);
  assign start_ok = start && ((state == ST_IDLE) || (state == ST_DONE));

  qubo_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_ok),
    .seed  (seed),
    .step  (in_init || in_gen),
    .value (r)
  );

  assign sel_a    = pick_parent(r[15:8]);
  assign sel_b    = pick_parent(r[23:16]);
  assign flip_pos = pick_bit(r[31:24]);
  assign xover    = (par_v[sel_a] & r[N-1:0]) | (par_v[sel_b] & ~r[N-1:0]);
  assign child    = xover ^ ({{(N-1){1'b0}}, 1'b1} << flip_pos);
  assign cand     = in_init ? r[N-1:0] : child;

  qubo_energy #(.N(N), .B(B), .IW(IW), .EW(EW)) u_energy (
    .clk    (clk),
    .we     (coef_we),
    .row    (coef_row),
    .col    (coef_col),
    .data   (coef_data),
    .cand   (cand),
    .energy (cand_e)
  );

  logic [MU-1:0][N-1:0]    next_v;
  logic [MU-1:0][EW-1:0]   next_e;
  logic [MU-1:0][POOL-1:0] sel_hit;

  qubo_select #(.N(N), .MU(MU), .LAMBDA(LAMBDA), .EW(EW)) u_select (
    .pool_v (({off_v, par_v})),
    .pool_e (({off_e, par_e})),
    .next_v (next_v),
    .next_e (next_e),
    .hit    (sel_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      gen    <= '0;
      par_v  <= '0;
      par_e  <= '0;
      off_v  <= '0;
      off_e  <= '0;
      best_v <= '0;
      best_e <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state  <= ST_INIT;
            cnt    <= '0;
            gen    <= '0;
            best_v <= '0;
            best_e <= E_MAX;
          end
        end
        ST_INIT: begin
          par_v[cnt[PW-1:0]] <= cand;
          par_e[cnt[PW-1:0]] <= cand_e;
          if (cand_e < best_e) begin
            best_v <= cand;
            best_e <= cand_e;
          end
          if (cnt == CW'(MU - 1)) begin
            state <= ST_GEN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_GEN: begin
          if (abort) begin
            state <= ST_DONE;
          end else begin
            off_v[cnt[OW-1:0]] <= child;
            off_e[cnt[OW-1:0]] <= cand_e;
            if (cnt == CW'(LAMBDA - 1)) begin
              state <= ST_SEL;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_SEL: begin
          par_v  <= next_v;
          par_e  <= next_e;
          best_v <= next_v[0];
          best_e <= $signed(next_e[0]);
          gen    <= gen + GW'(1);
          state  <= (gen == GW'(BUDGET - 1)) ? ST_DONE : ST_GEN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = in_init || in_gen || in_sel;
  assign done        = (state == ST_DONE);
  assign best_vec    = best_v;
  assign best_energy = best_e;

  // R4: the mutation step changes exactly one bit of the crossover result
  p_one_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_gen |-> ($countones(child ^ xover) == 1));

  // R5: every parent slot is filled by exactly one pool member, in order
  for (genvar s = 0; s < MU; s++) begin : g_sel_chk
    p_sel_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_sel |-> ($countones(sel_hit[s]) == 1));
    if (s < MU - 1) begin : g_ord
      p_sel_sorted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_sel |-> ($signed(next_e[s]) <= $signed(next_e[s+1])));
    end
  end

  // R6: a selection never raises the best energy
  p_best_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel |=> ($signed(best_e) <= $signed($past(best_e))));

  // R8: abort during offspring creation ends the run at the next edge
  p_abort_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gen && abort) |=> done);

  // R9: the held result stays put until a new start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(best_v) && $stable(best_e)));

endmodule

// File: tb/qubo_evo_core_tb.sv
`timescale 1ns/1ps
module qubo_evo_core_tb;

  localparam int N      = 6;
  localparam int B      = 8;
  localparam int MU     = 4;
  localparam int LAMBDA = 4;
  localparam int BUDGET = 500;
  localparam int IW     = $clog2(N);
  localparam int EW     = B + 2 * IW + 1;
  localparam int RUN_CYCLES = MU + BUDGET * (LAMBDA + 1);

  // stimulus table: {seed, planted optimum}
  localparam int NV = 4;
  localparam logic [31+N:0] VECS [NV] = '{
    {32'hACE1_0013, 6'b101101},
    {32'h1234_5678, 6'b000000},
    {32'hDEAD_BEEF, 6'b111111},
    {32'h0BAD_F00D, 6'b010010}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic [31:0] seed = 32'h1;
  logic coef_we = 1'b0;
  logic [IW-1:0] coef_row = '0;
  logic [IW-1:0] coef_col = '0;
  logic [B-1:0] coef_data = '0;
  logic busy, done;
  logic [N-1:0] best_vec;
  logic [EW-1:0] best_energy;

  always #10 clk = ~clk;

  qubo_evo_core #(.N(N), .B(B), .MU(MU), .LAMBDA(LAMBDA), .BUDGET(BUDGET)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .seed(seed),
    .coef_we(coef_we), .coef_row(coef_row), .coef_col(coef_col),
    .coef_data(coef_data), .busy(busy), .done(done),
    .best_vec(best_vec), .best_energy(best_energy)
  );

  int checks = 0;
  int errors = 0;
  int qm [N][N];
  int run_cycles;
  int mono_bad;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_energy(input logic [N-1:0] x);
    int e = 0;
    for (int i = 0; i < N; i++)
      for (int j = i; j < N; j++)
        if (x[i] && x[j]) e += qm[i][j];
    return e;
  endfunction

  function automatic int ref_min();
    int m = ref_energy('0);
    for (int v = 1; v < (1 << N); v++)
      if (ref_energy(N'(v)) < m) m = ref_energy(N'(v));
    return m;
  endfunction

  function automatic int got_energy();
    return int'($signed(best_energy));
  endfunction

  // write qm upper triangle; lower triangle gets junk the core must ignore (R3)
  task automatic load_q();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        coef_we   = 1'b1;
        coef_row  = IW'(i);
        coef_col  = IW'(j);
        coef_data = (i <= j) ? B'(qm[i][j]) : B'(-9);
        @(posedge clk); #1;
      end
    end
    coef_we = 1'b0;
  endtask

  task automatic plant(input logic [N-1:0] tgt);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i == j) qm[i][j] = tgt[i] ? -3 : 2;
        else if (i < j) qm[i][j] = (tgt[i] && tgt[j]) ? -1 : 0;
        else qm[i][j] = 0;
  endtask

  task automatic run(input logic [31:0] s);
    int prev;
    seed  = s;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    run_cycles = 0;
    mono_bad = 0;
    prev = int'($signed({1'b0, {(EW-1){1'b1}}}));
    while (run_cycles < RUN_CYCLES + 50) begin
      @(posedge clk); #1;
      run_cycles++;
      if (got_energy() > prev) mono_bad++;
      prev = got_energy();
      if (done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // table of planted problems
    for (int k = 0; k < NV; k++) begin
      plant(VECS[k][N-1:0]);
      load_q();
      run(VECS[k][31+N:N]);
      check(run_cycles == RUN_CYCLES, "R7", "cycles to done", run_cycles, RUN_CYCLES);
      check(mono_bad == 0, "R6", "best energy rises", mono_bad, 0);
      check(got_energy() == ref_energy(best_vec), "R6", "energy of best_vec",
            got_energy(), ref_energy(best_vec));
      // R10 R4 R3: reaching the optimum needs single-bit mutations and the
      // exact triangle-only energy
      check(got_energy() == ref_min(), "R10", "energy vs exhaustive", got_energy(), ref_min());
    end

    // R9: rewriting coefficients after done leaves the result alone
    begin
      logic [N-1:0] hv;
      int he;
      hv = best_vec;
      he = got_energy();
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) qm[i][j] = 5;
      load_q();
      repeat (5) @(posedge clk);
      #1;
      check(done == 1'b1, "R9", "done held", done, 1);
      check(best_vec == hv, "R9", "best_vec held", best_vec, hv);
      check(got_energy() == he, "R9", "best_energy held", got_energy(), he);
    end

    // R5 R2: all-zero matrix, every energy ties, parent 0 = seed low bits stays best
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) qm[i][j] = 0;
    load_q();
    run(32'h5A5A_C3A7);
    check(best_vec == 6'b100111, "R5", "tie keeps parent 0", best_vec, 6'b100111);
    check(got_energy() == 0, "R2", "zero-matrix energy", got_energy(), 0);
    check(busy == 1'b0, "R2", "busy cleared at done", busy, 0);

    // R8: abort in the offspring phase
    plant(6'b011011);
    load_q();
    seed  = 32'h7777_1111;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R2", "busy after start", {busy, done}, 2);
    repeat (6) @(posedge clk);
    #1;
    check(done == 1'b0, "R8", "done before abort", done, 0);
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    check(done == 1'b1, "R8", "done one edge after abort", done, 1);
    check(busy == 1'b0, "R8", "busy after abort", busy, 0);
    check(got_energy() == ref_energy(best_vec), "R8", "kept best is consistent",
          got_energy(), ref_energy(best_vec));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule